// File: doc/BRIEF.md
# Processor Status Register

This block is the 8-bit status register of a small accumulator-style processor core. It keeps three arithmetic flags (carry, nibble carry, zero), two reset-cause flags (power-down and time-out), and three bank-select bits. The ALU result and its two carries are captured under per-instruction update strobes. Sleep, watchdog-clear and watchdog-overflow events drive the reset-cause flags. Software reaches the register through a register-file write port.

The register exists once and decodes only the in-bank offset of the write address. It therefore answers in every bank, and the bank-select outputs are always valid. Subtraction is presented to the block as addition of the two's complement. The stored carries are the raw carry-outs of that addition, so 1 means that no borrow occurred.

Top module: `status_flags_reg`

## Requirements
- R1: `status` bit layout, LSB first: C (0), DC (1), Z (2), PD (3), TO (4), RP0 (5), RP1 (6), IRP (7). `bank_sel` always equals bit 5 and `ind_bank` always equals bit 7.
- R2: A cycle with `por` high makes `status` equal 8'h18 at the next edge (TO=PD=1, all else 0). This takes precedence over every other input.
- R3: When `upd_z` is high, Z takes 1 if `alu_res` is zero and 0 otherwise. When `upd_z` is low, Z keeps its value unless a status write changes it.
- R4: When `upd_c` / `upd_dc` is high, C / DC take `alu_cout` / `alu_hcout`. For a subtraction these hold 1 when no borrow occurs. When the strobe is low, the flag holds.
- R5: `sleep` clears PD. `clrwdt` sets PD. If both are high in the same cycle, sleep wins.
- R6: `clrwdt` or `sleep` sets TO. `wdt_ovf` clears TO and wins over either of them in the same cycle.
- R7: A write (`wr_en` with `wr_addr` equal to STATUS_ADDR, default 7'h03) loads bits 0–2 and 5–7 from `wr_data`.
- R8: Writes never change TO or PD. A write to any other address changes no bit.
- R9: In a write cycle, each of C, DC and Z whose update strobe is high takes its ALU value and not the written bit.
- R10: An ordinary reset (`rst`) clears bits 7:5 and leaves bits 4:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| rst | input | 1 | Ordinary reset, synchronous, active high |
| alu_res | input | 8 | ALU result |
| alu_cout | input | 1 | ALU carry out of bit 7 |
| alu_hcout | input | 1 | ALU carry from bit 3 into bit 4 |
| upd_c | input | 1 | Current instruction updates C |
| upd_dc | input | 1 | Current instruction updates DC |
| upd_z | input | 1 | Current instruction updates Z |
| clrwdt | input | 1 | Watchdog-clear instruction executed |
| sleep | input | 1 | Sleep instruction executed |
| wdt_ovf | input | 1 | Watchdog overflow event |
| wr_en | input | 1 | Register-file write strobe |
| wr_addr | input | ADDR_W | In-bank write address |
| wr_data | input | 8 | Write data |
| status | output | 8 | Status byte |
| bank_sel | output | 1 | Direct-addressing bank bit |
| ind_bank | output | 1 | Indirect-addressing bank bit |

## Verification
Two collisions carry the risk. The first is a status write in the same cycle as ALU flag updates. The second is a watchdog overflow in the same cycle as a watchdog clear. The bench drives a write of set bits together with a nonzero result under the Z strobe only. It then checks that Z follows the ALU while C and DC follow the written data. It also raises `wdt_ovf` and `clrwdt` together and expects TO at 0 with PD at 1.

// File: rtl/status_flags_reg.sv
module status_flags_reg #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 7'h03
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic [7:0]        alu_res,
  input  logic              alu_cout,
  input  logic              alu_hcout,
  input  logic              upd_c,
  input  logic              upd_dc,
  input  logic              upd_z,
  input  logic              clrwdt,
  input  logic              sleep,
  input  logic              wdt_ovf,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        status,
  output logic              bank_sel,
  output logic              ind_bank
);
  logic       c_q, dc_q, z_q, pd_q, to_q;
  logic [2:0] bank_q;

  wire hit    = wr_en && (wr_addr == STATUS_ADDR);
  wire z_next = (alu_res == 8'h00);

  always_ff @(posedge clk) begin
    if (por) begin
      {bank_q, to_q, pd_q, z_q, dc_q, c_q} <= 8'h18;
    end else if (rst) begin
      bank_q <= 3'b000;
    end else begin
      if (upd_c)    c_q  <= alu_cout;
      else if (hit) c_q  <= wr_data[0];
      if (upd_dc)   dc_q <= alu_hcout;
      else if (hit) dc_q <= wr_data[1];
      if (upd_z)    z_q  <= z_next;
      else if (hit) z_q  <= wr_data[2];
      if (hit)      bank_q <= wr_data[7:5];
      if (sleep)        pd_q <= 1'b0;
      else if (clrwdt)  pd_q <= 1'b1;
      if (wdt_ovf)               to_q <= 1'b0;
      else if (clrwdt || sleep)  to_q <= 1'b1;
    end
  end

  assign status   = {bank_q, to_q, pd_q, z_q, dc_q, c_q};
  assign bank_sel = bank_q[0];
  assign ind_bank = bank_q[2];
endmodule

// File: rtl/status_flags_chk.sv
module status_flags_chk (
  input logic       clk,
  input logic       por,
  input logic       rst,
  input logic [7:0] alu_res,
  input logic       alu_cout,
  input logic       upd_c,
  input logic       upd_z,
  input logic       clrwdt,
  input logic       sleep,
  input logic       wdt_ovf,
  input logic [7:0] status
);
  // R3
  z_update_chk: assert property (@(posedge clk) disable iff (por)
    (!rst && upd_z) |=> (status[2] == ($past(alu_res) == 8'h00)));
  // R4
  c_update_chk: assert property (@(posedge clk) disable iff (por)
    (!rst && upd_c) |=> (status[0] == $past(alu_cout)));
  // R5
  pd_sleep_chk: assert property (@(posedge clk) disable iff (por)
    (!rst && sleep) |=> !status[3]);
  // R6
  to_overflow_chk: assert property (@(posedge clk) disable iff (por)
    (!rst && wdt_ovf) |=> !status[4]);
  // R8
  reset_cause_hold_chk: assert property (@(posedge clk) disable iff (por)
    (!sleep && !clrwdt && !wdt_ovf) |=> $stable(status[4:3]));
  // R10
  soft_reset_chk: assert property (@(posedge clk) disable iff (por)
    rst |=> (status[7:5] == 3'b000 && $stable(status[4:0])));
endmodule

bind status_flags_reg status_flags_chk u_chk (
  .clk(clk), .por(por), .rst(rst), .alu_res(alu_res), .alu_cout(alu_cout),
  .upd_c(upd_c), .upd_z(upd_z), .clrwdt(clrwdt), .sleep(sleep),
  .wdt_ovf(wdt_ovf), .status(status)
);

// File: tb/tb_status_flags_reg.sv
module tb_status_flags_reg;
  logic       clk = 1'b0;
  logic       por, rst, alu_cout, alu_hcout, upd_c, upd_dc, upd_z;
  logic       clrwdt, sleep, wdt_ovf, wr_en;
  logic [7:0] alu_res, wr_data;
  logic [6:0] wr_addr;
  logic [7:0] status;
  logic       bank_sel, ind_bank;
  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_st;

  always #10 clk = ~clk;

  status_flags_reg dut (
    .clk(clk), .por(por), .rst(rst), .alu_res(alu_res), .alu_cout(alu_cout),
    .alu_hcout(alu_hcout), .upd_c(upd_c), .upd_dc(upd_dc), .upd_z(upd_z),
    .clrwdt(clrwdt), .sleep(sleep), .wdt_ovf(wdt_ovf), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .status(status),
    .bank_sel(bank_sel), .ind_bank(ind_bank)
  );

  task automatic idle();
    por = 0; rst = 0; alu_res = 8'h55; alu_cout = 0; alu_hcout = 0;
    upd_c = 0; upd_dc = 0; upd_z = 0; clrwdt = 0; sleep = 0; wdt_ovf = 0;
    wr_en = 0; wr_addr = 7'h00; wr_data = 8'h00;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_st(string req);
    chk(req, status, exp_st);
    chk({req, " R1 bank outputs"}, {6'd0, ind_bank, bank_sel}, {6'd0, exp_st[7], exp_st[5]});
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic t_power_on();
    @(negedge clk); idle(); por = 1;
    step();
    exp_st = 8'h18;
    chk_st("R2 power-on");
  endtask

  task automatic wr(logic [6:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
  endtask

  task automatic t_writes();
    wr(7'h03, 8'hE7); step();
    exp_st = 8'hFF; chk_st("R7 write all");
    wr(7'h03, 8'h00); step();
    exp_st = 8'h18; chk_st("R8 TO/PD not writable");
    wr(7'h04, 8'hFF); step();
    chk_st("R8 other address ignored");
    wr(7'h03, 8'h20); step();
    exp_st = 8'h38; chk_st("R7 RP0 alone");
  endtask

  task automatic alu(logic [7:0] a, logic [7:0] b, logic sub, logic uc, logic udc, logic uz);
    logic [7:0] bx;
    logic [8:0] s;
    logic [4:0] h;
    bx = sub ? ~b : b;
    s = {1'b0, a} + {1'b0, bx} + {8'd0, sub};
    h = {1'b0, a[3:0]} + {1'b0, bx[3:0]} + {4'd0, sub};
    alu_res = s[7:0]; alu_cout = s[8]; alu_hcout = h[4];
    upd_c = uc; upd_dc = udc; upd_z = uz;
    if (uc)  exp_st[0] = s[8];
    if (udc) exp_st[1] = h[4];
    if (uz)  exp_st[2] = (s[7:0] == 8'h00);
  endtask

  task automatic t_alu();
    alu(8'h0F, 8'h01, 0, 1, 1, 1); step();
    chk_st("R4 add nibble carry");
    chk("R3 add nonzero", {7'd0, status[2]}, 8'h00);
    alu(8'h05, 8'h05, 1, 1, 1, 1); step();
    chk_st("R3 R4 sub equal");
    chk("R4 no borrow C=1", {6'd0, status[1:0]}, 8'h03);
    alu(8'h03, 8'h05, 1, 1, 1, 1); step();
    chk_st("R4 sub with borrow");
    alu(8'h00, 8'h00, 0, 0, 0, 1); step();
    chk_st("R3 zero-only update, C/DC hold");
    alu(8'hF0, 8'h20, 0, 0, 0, 0); step();
    chk_st("R4 no strobe holds flags");
  endtask

  task automatic t_override();
    wr(7'h03, 8'h07);
    alu(8'h01, 8'h01, 0, 0, 0, 1);
    exp_st[7:5] = 3'b000; exp_st[1:0] = 2'b11;
    step();
    chk_st("R9 Z strobe beats write");
    wr(7'h03, 8'h00);
    alu(8'hFF, 8'h01, 0, 1, 1, 0);
    exp_st[2] = 1'b0;
    step();
    chk_st("R9 carries beat write");
  endtask

  task automatic t_reset_cause();
    sleep = 1; exp_st[3] = 0; exp_st[4] = 1; step();
    chk_st("R5 sleep clears PD");
    clrwdt = 1; exp_st[3] = 1; step();
    chk_st("R5 clrwdt sets PD");
    wdt_ovf = 1; exp_st[4] = 0; step();
    chk_st("R6 overflow clears TO");
    sleep = 1; exp_st[3] = 0; exp_st[4] = 1; step();
    chk_st("R6 sleep sets TO");
    wdt_ovf = 1; clrwdt = 1; exp_st[3] = 1; exp_st[4] = 0; step();
    chk_st("R6 overflow wins over clrwdt");
    sleep = 1; clrwdt = 1; exp_st[3] = 0; exp_st[4] = 1; step();
    chk_st("R5 sleep wins over clrwdt");
  endtask

  task automatic t_soft_reset();
    wr(7'h03, 8'hA5); step();
    exp_st = {3'b101, exp_st[4:3], 3'b101}; chk_st("R7 write before reset");
    rst = 1; wr(7'h03, 8'hFF); step();
    exp_st[7:5] = 3'b000; chk_st("R10 ordinary reset");
    por = 1; step();
    exp_st = 8'h18; chk_st("R2 power-on after use");
  endtask

  initial begin
    idle(); por = 1; exp_st = 8'h18;
    t_power_on();
    t_writes();
    t_alu();
    t_override();
    t_reset_cause();
    t_soft_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule